// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block decides which interrupt a 16550-style UART reports and raises its interrupt request. Five sources compete under a fixed priority: line-status errors, character timeout, received data, transmit holding register empty and modem-status change. The block reports the winner as a 4-bit identification code, adds FIFO-enabled flags in the top two bits, and drives a registered interrupt request that is high whenever some source is pending.

The block also owns two pieces of pending state whose lifetime depends on register accesses. The first is the sticky transmit-empty flag. An enable-register write or a fresh empty holding register sets it. A holding-register write clears it, and so does a read of the identification register that returned the transmit-empty code. The second is the set of line-status error bits. Overrun and break stay set until the line status register is read. Parity and framing follow the receive path. The surrounding UART supplies the status levels and the access strobes. Serial shifting, baud generation and FIFO storage sit outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, iir_o reads 0x01, irq_o is low, lsr_err_o is 0 and the transmit-empty pending flag is clear.
- R2: When several sources are active, the reported source is the highest of: line status, then character timeout, then received data, then transmit empty, then modem status.
- R3: iir_o[3:0] is 0x6 for line status, 0xC for character timeout, 0x4 for received data, 0x2 for transmit empty, 0x0 for modem status and 0x1 when nothing is pending. iir_o[5:4] always read 0.
- R4: A line-status interrupt needs ier_i[2] and at least one bit of lsr_err_o set.
- R5: The character-timeout source (timeout_i) is enabled only by ier_i[0]. It has no enable of its own.
- R6: A received-data interrupt needs ier_i[0] and data_ready_i. When fifo_en_i is 1, rx_count_i must also be at least the trigger level that trig_sel_i selects: 0 selects 1, 1 selects FIFO_DEPTH/4, 2 selects FIFO_DEPTH/2 and 3 selects FIFO_DEPTH-2.
- R7: The transmit-empty pending flag is set on the clock edge of an ier_wr_i pulse while thr_empty_i is 1, or when thr_empty_i rises. It is cleared by thr_wr_i, and the clear wins over a set in the same cycle. Its interrupt needs ier_i[1].
- R8: An iir_rd_i pulse clears the transmit-empty pending flag only when iir_o[3:0] reads 0x2 in that cycle. A read that returns any other code leaves the flag as it was.
- R9: iir_o[7:6] reads 11 while fifo_en_i is 1 and 00 otherwise.
- R10: lsr_err_o bit 0 (overrun) and bit 3 (break) are set by the matching err_set_i bit and stay set until an lsr_rd_i pulse clears them. A set in the same cycle as the read wins. Bit 1 (parity) and bit 2 (framing) follow err_set_i one cycle later.
- R11: irq_o is registered: in each cycle it equals whether iir_o[3:0] differed from 0x1 in the previous cycle.
- R12: A modem-status interrupt needs ier_i[3] and any bit of msr_delta_i set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Interrupt enables: bit0 rx data/timeout, bit1 tx empty, bit2 line status, bit3 modem |
| fifo_en_i | input | 1 | FIFO mode enabled |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_count_i | input | $clog2(FIFO_DEPTH+1) | Receive FIFO fill count |
| data_ready_i | input | 1 | Receive data available |
| err_set_i | input | 4 | Error events: bit0 overrun, bit1 parity, bit2 framing, bit3 break |
| lsr_rd_i | input | 1 | Line status register read strobe |
| timeout_i | input | 1 | Character timeout pending |
| thr_empty_i | input | 1 | Transmit holding register empty |
| ier_wr_i | input | 1 | Enable register write strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| msr_delta_i | input | 4 | Modem status delta bits |
| lsr_err_o | output | 4 | Current line status error bits |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH set to 8. The four trigger levels then become 1, 2, 4 and 6, and the full count range of 0 to 8 stays small. Random fill counts therefore often land right on the trigger-level boundary, one below it, and at a full FIFO. The same small range lets random enables and strobes often stack several sources at once. This exercises the priority ladder and the read-clear paths together.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  localparam int ERR_W   = 4;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;
  // overrun and break hold until read, parity/framing follow the rx path
  localparam logic [ERR_W-1:0] ERR_STICKY = 4'b1001;

  function automatic int trig_level(int depth, int sel);
    case (sel)
      0:       return 1;
      1:       return depth / 4;
      2:       return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_lsr_err.sv
module uart_irq_lsr_err
  import uart_irq_pkg::*;
#(
  parameter int W = ERR_W,
  parameter logic [W-1:0] STICKY = ERR_STICKY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  output logic [W-1:0] err_o
);
  logic [W-1:0] err_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (STICKY[b]) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q[b] <= 1'b0;
        else         err_q[b] <= set_i[b] | (err_q[b] & ~rd_i);
      end
    end else begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q[b] <= 1'b0;
        else         err_q[b] <= set_i[b];
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/uart_irq_thr_pend.sv
module uart_irq_thr_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_empty_i,
  input  logic ier_wr_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  input  logic id_is_thre_i,
  output logic pend_o
);
  logic pend_q, empty_q;
  logic set, clr;

  assign set = (ier_wr_i & thr_empty_i) | (thr_empty_i & ~empty_q);
  assign clr = thr_wr_i | (iir_rd_i & id_is_thre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      empty_q <= thr_empty_i;
      if (clr)      pend_q <= 1'b0;
      else if (set) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [3:0]       ier_i,
  input  logic             err_any_i,
  input  logic             timeout_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             tx_pend_i,
  input  logic             msr_any_i,
  output irq_id_e          id_o
);
  localparam int LVL0 = trig_level(FIFO_DEPTH, 0);
  localparam int LVL1 = trig_level(FIFO_DEPTH, 1);
  localparam int LVL2 = trig_level(FIFO_DEPTH, 2);
  localparam int LVL3 = trig_level(FIFO_DEPTH, 3);

  logic [CNT_W-1:0] lvl;
  logic             at_lvl;

  always_comb begin
    case (trig_sel_i)
      2'd0:    lvl = CNT_W'(LVL0);
      2'd1:    lvl = CNT_W'(LVL1);
      2'd2:    lvl = CNT_W'(LVL2);
      default: lvl = CNT_W'(LVL3);
    endcase
  end

  assign at_lvl = !fifo_en_i || (rx_count_i >= lvl);

  always_comb begin
    if (ier_i[2] && err_any_i)                      id_o = ID_LINE;
    else if (ier_i[0] && timeout_i)                 id_o = ID_TIMEOUT;
    else if (ier_i[0] && data_ready_i && at_lvl)    id_o = ID_RXDATA;
    else if (ier_i[1] && tx_pend_i)                 id_o = ID_THRE;
    else if (ier_i[3] && msr_any_i)                 id_o = ID_MODEM;
    else                                            id_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       ier_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             data_ready_i,
  input  logic [3:0]       err_set_i,
  input  logic             lsr_rd_i,
  input  logic             timeout_i,
  input  logic             thr_empty_i,
  input  logic             ier_wr_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic [3:0]       msr_delta_i,
  output logic [3:0]       lsr_err_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  irq_id_e id;
  logic    tx_pend;
  logic    irq_q;

  uart_irq_lsr_err u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set_i),
    .rd_i   (lsr_rd_i),
    .err_o  (lsr_err_o)
  );

  uart_irq_thr_pend u_thr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .thr_empty_i  (thr_empty_i),
    .ier_wr_i     (ier_wr_i),
    .thr_wr_i     (thr_wr_i),
    .iir_rd_i     (iir_rd_i),
    .id_is_thre_i (id == ID_THRE),
    .pend_o       (tx_pend)
  );

  uart_irq_prio #(.FIFO_DEPTH(FIFO_DEPTH)) u_prio (
    .ier_i        (ier_i),
    .err_any_i    (|lsr_err_o),
    .timeout_i    (timeout_i),
    .data_ready_i (data_ready_i),
    .fifo_en_i    (fifo_en_i),
    .trig_sel_i   (trig_sel_i),
    .rx_count_i   (rx_count_i),
    .tx_pend_i    (tx_pend),
    .msr_any_i    (|msr_delta_i),
    .id_o         (id)
  );

  assign iir_o = {{2{fifo_en_i}}, 2'b00, id};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (id != ID_NONE);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] ier_i,
  input logic       fifo_en_i,
  input logic [3:0] err_set_i,
  input logic       lsr_rd_i,
  input logic       thr_wr_i,
  input logic [3:0] lsr_err_o,
  input logic [7:0] iir_o,
  input logic       irq_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_IRQ_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (irq_o == ($past(iir_o[3:0]) != 4'h1))); // R11

  AST_ID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC}) && iir_o[5:4] == 2'b00); // R3

  AST_FIFO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[7:6] == {2{fifo_en_i}}); // R9

  AST_LINE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i[2] && (|lsr_err_o)) |-> iir_o[3:0] == 4'h6); // R2

  AST_RX_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_i[0] |-> !(iir_o[3:0] inside {4'hC, 4'h4})); // R5

  AST_THR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> iir_o[3:0] != 4'h2); // R7

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i[0] |=> lsr_err_o[0]); // R10

  AST_OVR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !err_set_i[0]) |=> !lsr_err_o[0]); // R10
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ier_i     (ier_i),
  .fifo_en_i (fifo_en_i),
  .err_set_i (err_set_i),
  .lsr_rd_i  (lsr_rd_i),
  .thr_wr_i  (thr_wr_i),
  .lsr_err_o (lsr_err_o),
  .iir_o     (iir_o),
  .irq_o     (irq_o)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]    ier = '0;
  logic          fifo_en = 1'b0;
  logic [1:0]    trig_sel = '0;
  logic [CW-1:0] rx_count = '0;
  logic          data_ready = 1'b0;
  logic [3:0]    err_set = '0;
  logic          lsr_rd = 1'b0;
  logic          timeout = 1'b0;
  logic          thr_empty = 1'b1;
  logic          ier_wr = 1'b0;
  logic          thr_wr = 1'b0;
  logic          iir_rd = 1'b0;
  logic [3:0]    msr_delta = '0;
  logic [3:0]    lsr_err;
  logic [7:0]    iir;
  logic          irq;

  uart_irq_ident #(.FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier), .fifo_en_i(fifo_en),
    .trig_sel_i(trig_sel), .rx_count_i(rx_count), .data_ready_i(data_ready),
    .err_set_i(err_set), .lsr_rd_i(lsr_rd), .timeout_i(timeout),
    .thr_empty_i(thr_empty), .ier_wr_i(ier_wr), .thr_wr_i(thr_wr),
    .iir_rd_i(iir_rd), .msr_delta_i(msr_delta), .lsr_err_o(lsr_err),
    .iir_o(iir), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;

  logic [3:0] m_err = '0;
  logic       m_pend = 1'b0;
  logic       m_prev_empty = 1'b1;
  logic       m_irq = 1'b0;

  function automatic int lvl_of(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return DEPTH / 4;
      2'd2: return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  function automatic logic [3:0] exp_id();
    if (ier[2] && |m_err) return 4'h6;
    if (ier[0] && timeout) return 4'hC;
    if (ier[0] && data_ready && (!fifo_en || int'(rx_count) >= lvl_of(trig_sel))) return 4'h4;
    if (ier[1] && m_pend) return 4'h2;
    if (ier[3] && |msr_delta) return 4'h0;
    return 4'h1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // apply one clock with current inputs, update model, compare at negedge
  task automatic step(string tag);
    logic [3:0] id_b;
    logic set, clr;
    id_b = exp_id();
    set = (ier_wr & thr_empty) | (thr_empty & ~m_prev_empty);
    clr = thr_wr | (iir_rd & (id_b == 4'h2));
    @(posedge clk);
    m_err[0] = err_set[0] | (m_err[0] & ~lsr_rd);
    m_err[3] = err_set[3] | (m_err[3] & ~lsr_rd);
    m_err[1] = err_set[1];
    m_err[2] = err_set[2];
    if (clr) m_pend = 1'b0;
    else if (set) m_pend = 1'b1;
    m_prev_empty = thr_empty;
    m_irq = (id_b != 4'h1);
    @(negedge clk);
    check(tag, 32'(iir), 32'({{2{fifo_en}}, 2'b00, exp_id()}), "iir");
    check("R11", 32'(irq), 32'(m_irq), "irq");
    check("R10", 32'(lsr_err), 32'(m_err), "lsr_err");
  endtask

  task automatic quiet();
    err_set = '0; lsr_rd = 0; ier_wr = 0; thr_wr = 0; iir_rd = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", 32'(iir), 32'h01, "iir");
    check("R1", 32'(irq), 32'h0, "irq");
    check("R1", 32'(lsr_err), 32'h0, "lsr_err");
    rst_n = 1'b1;
    @(negedge clk);
    ier = 4'b0010; step("R1"); // pending flag clear after reset

    // priority ladder: all sources active, peel them off one by one
    ier = 4'hF; ier_wr = 1; err_set = 4'b0001; timeout = 1; data_ready = 1;
    msr_delta = 4'b0100; step("R2");
    quiet(); step("R4");
    lsr_rd = 1; step("R2");
    quiet(); timeout = 0; step("R6");
    data_ready = 0; step("R7");
    iir_rd = 1; step("R8");
    quiet(); step("R12");
    msr_delta = 0; step("R3");

    // timeout masked by rx-data enable
    ier = 4'b1110; timeout = 1; data_ready = 1; step("R5");
    ier = 4'b0001; step("R5");
    timeout = 0; data_ready = 0;

    // trigger boundary, level select 1 -> DEPTH/4
    fifo_en = 1; trig_sel = 2'd1; data_ready = 1; rx_count = CW'(DEPTH/4 - 1); step("R6");
    rx_count = CW'(DEPTH/4); step("R6");
    trig_sel = 2'd3; step("R9");
    fifo_en = 0; step("R9");
    data_ready = 0; rx_count = '0;

    // sticky bits: set wins over read, parity follows input
    ier = 4'b0100; err_set = 4'b1010; lsr_rd = 1; step("R10");
    quiet(); step("R10");
    lsr_rd = 1; step("R10");
    quiet();

    // iir read with a different code keeps the tx flag
    ier = 4'b0011; thr_empty = 0; step("R7");
    thr_empty = 1; step("R7");
    timeout = 1; iir_rd = 1; step("R8");
    quiet(); timeout = 0; step("R8");
    ier_wr = 1; thr_wr = 1; step("R7");
    quiet();

    for (int i = 0; i < 3000; i++) begin
      ier        = 4'($urandom);
      fifo_en    = 1'($urandom);
      trig_sel   = 2'($urandom);
      rx_count   = CW'($urandom_range(0, DEPTH));
      data_ready = 1'($urandom);
      err_set    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      lsr_rd     = ($urandom_range(0, 3) == 0);
      timeout    = ($urandom_range(0, 3) == 0);
      thr_empty  = ($urandom_range(0, 2) != 0);
      ier_wr     = ($urandom_range(0, 4) == 0);
      thr_wr     = ($urandom_range(0, 5) == 0);
      iir_rd     = ($urandom_range(0, 2) == 0);
      msr_delta  = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      step("R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule